// File: doc/BRIEF.md
# Paced Frame Readout Controller

This block hands one stored video frame to a slow byte-wide host port. A host raises a request. The block then waits for the capture side to report that the frame in memory is complete. It then holds off further capture writes and walks the frame buffer in strictly ascending address order, from a fixed first address to a fixed last address. Each read is spaced by a programmable number of system clocks, so the readout runs far below the capture rate.

Each 16-bit word read from memory is split into two bytes. The luma byte (bits 15:8) goes out first and the chroma byte (bits 7:0) second, over a valid/ready byte port. An acknowledge line tells the host that the frame is being delivered. The acknowledge stays high until the byte from the last address is taken. Then the acknowledge drops, writes are allowed again, and the block waits for the next request. Memory electrical timing is outside this block. Read data is taken to be valid in the cycle after the read strobe and held through that cycle.

Top module: `frame_readout_dma`

## Requirements
- R1: While reset is low and in the first cycle after it, `read_ack`, `wr_inhibit`, `rd_strobe` and `byte_valid` are all 0.
- R2: A `frame_done` pulse with no pending request has no effect: `wr_inhibit`, `read_ack` and `rd_strobe` stay 0.
- R3: After a request, the block waits for `frame_done`. `wr_inhibit` rises in the cycle after `frame_done` is seen, and `read_ack` rises one cycle later. `read_ack` is never high without `wr_inhibit`.
- R4: The first `rd_strobe` of a frame comes in the cycle after `read_ack` rises. `rd_strobe` is only ever high while `read_ack` is high.
- R5: The strobed addresses run START_ADDR, START_ADDR+1, … STOP_ADDR, each exactly once, with no skipped row.
- R6: Two consecutive strobes are at least PACE_CYC cycles apart. With `byte_ready` held high, they are exactly max(PACE_CYC, 5) cycles apart.
- R7: The block takes `rd_data` in the cycle after the strobe. For each word it sends bits 15:8 and then bits 7:0, and it sends no byte in a strobe cycle.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` and `byte_data` hold in the next cycle.
- R9: In the cycle after the byte from STOP_ADDR is accepted, `read_ack` and `wr_inhibit` both fall, and a new request is then served.
- R10: A request or `frame_done` arriving during a readout neither restarts nor lengthens it: the frame still yields exactly 2×(STOP_ADDR−START_ADDR+1) bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| read_req | input | 1 | Host request for one frame, sampled while idle |
| frame_done | input | 1 | One-cycle pulse: the whole frame is in memory |
| rd_data | input | PIX_W | Memory word, valid the cycle after `rd_strobe` |
| byte_ready | input | 1 | Output port accepts the current byte |
| rd_addr | output | ADDR_W | Read address from the read counter |
| rd_strobe | output | 1 | One-cycle memory read request |
| wr_inhibit | output | 1 | High: capture writes must stop |
| read_ack | output | 1 | Frame is being delivered |
| byte_valid | output | 1 | `byte_data` holds a byte to send |
| byte_data | output | PIX_W/2 | Outgoing byte, luma first |

## Verification
The assertions take `frame_done` to be a single-cycle pulse. They take the memory to return the strobed word in the following cycle, and they take `byte_ready` to be free to change in any cycle. The bench returns a marker value in every cycle except the one after a strobe, so an early or late capture shows up as a wrong byte. It drives `byte_ready` as always high, alternating, and pseudo-random. It sends its extra requests and completion pulses only as isolated one-cycle pulses, either while idle or partway through a readout.

// File: rtl/frd_pkg.sv
// Shared types for the frame readout controller.
// Assumes: nothing beyond IEEE 1800-2017.
package frd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FRAME,
        ST_PREP,
        ST_FETCH,
        ST_STROBE,
        ST_LATCH,
        ST_SEND_HI,
        ST_SEND_LO
    } frd_state_t;
endpackage

// File: rtl/frd_pace_timer.sv
// Counts cycles since the last read strobe, saturating at PACE_CYC.
// Assumes: PACE_CYC >= 2. The preset makes the next strobe eligible at once.
module frd_pace_timer #(
    parameter int PACE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic restart,
    output logic pace_ok
);
    localparam int CW = $clog2(PACE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PACE_CYC);
    localparam logic [CW-1:0] READY_AT = CW'(PACE_CYC - 1);

    logic [CW-1:0] gap_q;

    // Track elapsed cycles since the most recent strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          gap_q <= '0;
        else if (preset)     gap_q <= LIMIT;
        else if (restart)    gap_q <= CW'(1);
        else if (gap_q < LIMIT) gap_q <= gap_q + CW'(1);
    end

    assign pace_ok = (gap_q >= READY_AT);
endmodule

// File: rtl/frd_addr_counter.sv
// Sequential read address counter, loaded with the first address and stepped by one.
// Assumes: load and step are never asserted together.
module frd_addr_counter #(
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-1:0] START_ADDR = '0,
    parameter logic [ADDR_W-1:0] STOP_ADDR  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    // Hold the current read address.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= START_ADDR;
        else if (load) addr <= START_ADDR;
        else if (step) addr <= addr + ADDR_W'(1);
    end

    assign at_last = (addr == STOP_ADDR);
endmodule

// File: rtl/frd_serializer.sv
// Holds one memory word and presents its upper or lower half as the output byte.
// Assumes: PIX_W is even; the upper half is luma and is sent first.
module frd_serializer #(
    parameter int PIX_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               pick_low,
    input  logic [PIX_W-1:0]   word_in,
    output logic [PIX_W/2-1:0] byte_out
);
    localparam int BYTE_W = PIX_W / 2;

    logic [PIX_W-1:0] word_q;

    // Latch the word returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= word_in;
    end

    assign byte_out = pick_low ? word_q[BYTE_W-1:0] : word_q[PIX_W-1:BYTE_W];
endmodule

// File: rtl/frame_readout_dma.sv
// Frame readout controller. It serves one host request: it waits for frame completion,
// inhibits writes, reads START_ADDR..STOP_ADDR paced by PACE_CYC cycles, and
// emits each word as two bytes.
// Assumes: frame_done is a one-cycle pulse; rd_data is valid the cycle after rd_strobe.
module frame_readout_dma #(
    parameter int ADDR_W = 20,
    parameter int PIX_W  = 16,
    parameter logic [ADDR_W-1:0] START_ADDR = '0,
    parameter logic [ADDR_W-1:0] STOP_ADDR  = 20'd659999,
    parameter int PACE_CYC = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               read_req,
    input  logic               frame_done,
    input  logic [PIX_W-1:0]   rd_data,
    input  logic               byte_ready,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_strobe,
    output logic               wr_inhibit,
    output logic               read_ack,
    output logic               byte_valid,
    output logic [PIX_W/2-1:0] byte_data
);
    import frd_pkg::*;

    frd_state_t state_q, state_d;
    logic pace_ok, at_last, step_addr;

    // Advance the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Choose the next state from the request, completion, pacing and byte handshake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (read_req)   state_d = ST_WAIT_FRAME;
            ST_WAIT_FRAME: if (frame_done) state_d = ST_PREP;
            ST_PREP:                       state_d = ST_FETCH;
            ST_FETCH:      if (pace_ok)    state_d = ST_STROBE;
            ST_STROBE:                     state_d = ST_LATCH;
            ST_LATCH:                      state_d = ST_SEND_HI;
            ST_SEND_HI:    if (byte_ready) state_d = ST_SEND_LO;
            ST_SEND_LO:    if (byte_ready) state_d = at_last ? ST_IDLE : ST_FETCH;
            default:                       state_d = ST_IDLE;
        endcase
    end

    assign wr_inhibit = (state_q != ST_IDLE) && (state_q != ST_WAIT_FRAME);
    assign read_ack   = wr_inhibit && (state_q != ST_PREP);
    assign rd_strobe  = (state_q == ST_STROBE);
    assign byte_valid = (state_q == ST_SEND_HI) || (state_q == ST_SEND_LO);
    assign step_addr  = (state_q == ST_SEND_LO) && byte_ready && !at_last;

    frd_pace_timer #(
        .PACE_CYC (PACE_CYC)
    ) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (state_q == ST_PREP),
        .restart (rd_strobe),
        .pace_ok (pace_ok)
    );

    frd_addr_counter #(
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR),
        .STOP_ADDR  (STOP_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_PREP),
        .step    (step_addr),
        .addr    (rd_addr),
        .at_last (at_last)
    );

    frd_serializer #(
        .PIX_W (PIX_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (state_q == ST_LATCH),
        .pick_low (state_q == ST_SEND_LO),
        .word_in  (rd_data),
        .byte_out (byte_data)
    );
endmodule

// File: rtl/frame_readout_chk.sv
// Property checker for frame_readout_dma, attached by bind below.
// Assumes: frame_done is a single-cycle pulse.
module frame_readout_chk #(
    parameter int ADDR_W = 20,
    parameter int PIX_W  = 16,
    parameter logic [ADDR_W-1:0] STOP_ADDR = '1,
    parameter int PACE_CYC = 50
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_done,
    input logic               rd_strobe,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               wr_inhibit,
    input logic               read_ack,
    input logic               byte_valid,
    input logic               byte_ready,
    input logic [PIX_W/2-1:0] byte_data
);
    localparam int CW = $clog2(PACE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PACE_CYC);

    logic [CW-1:0] gap_q;
    logic          seen_q;

    // Measure the spacing between strobes independently of the design's timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (rd_strobe) begin
            gap_q  <= CW'(1);
            seen_q <= 1'b1;
        end else if (gap_q < LIMIT) begin
            gap_q <= gap_q + CW'(1);
        end
    end

    AST_ACK_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        read_ack |-> wr_inhibit); // R3
    AST_INHIBIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_inhibit) |-> $past(frame_done)); // R3
    AST_STROBE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> read_ack); // R4
    AST_ADDR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (rd_addr <= STOP_ADDR)); // R5
    AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && seen_q) |-> (gap_q >= LIMIT)); // R6
    AST_NO_BYTE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> !byte_valid); // R7
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data))); // R8
    AST_BYTE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> read_ack); // R9
endmodule

bind frame_readout_dma frame_readout_chk #(
    .ADDR_W    (ADDR_W),
    .PIX_W     (PIX_W),
    .STOP_ADDR (STOP_ADDR),
    .PACE_CYC  (PACE_CYC)
) u_frd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .rd_strobe  (rd_strobe),
    .rd_addr    (rd_addr),
    .wr_inhibit (wr_inhibit),
    .read_ack   (read_ack),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .byte_data  (byte_data)
);

// File: tb/test_frame_readout_dma.sv
`timescale 1ns/1ps
module test_frame_readout_dma;
    localparam int AW = 6;
    localparam logic [AW-1:0] ST = 6'd5;
    localparam logic [AW-1:0] SP = 6'd16;
    localparam int PACE = 7;
    localparam int NPIX = SP - ST + 1;
    localparam int GAP_FAST = (PACE > 5) ? PACE : 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic read_req = 1'b0;
    logic frame_done = 1'b0;
    logic [15:0] rd_data = 16'hDEAD;
    logic byte_ready = 1'b1;
    logic [AW-1:0] rd_addr;
    logic rd_strobe, wr_inhibit, read_ack, byte_valid;
    logic [7:0] byte_data;

    int errors = 0;
    int checks = 0;
    int mode = 0;
    logic running = 1'b0;
    int cyc = 0;
    int nstrb, last_strb, last_acc, head, tail;
    logic [AW-1:0] exp_addr;
    logic [7:0] exp_q [0:63];
    logic done_flag, ack_prev, pend, hold_pend;
    logic [AW-1:0] pend_addr;
    logic [7:0] hold_data;
    logic [7:0] lfsr = 8'hB5;

    always #2.5 clk = ~clk;

    frame_readout_dma #(
        .ADDR_W (AW), .PIX_W (16), .START_ADDR (ST), .STOP_ADDR (SP), .PACE_CYC (PACE)
    ) i_frame_readout_dma (
        .clk (clk), .rst_n (rst_n), .read_req (read_req), .frame_done (frame_done),
        .rd_data (rd_data), .byte_ready (byte_ready), .rd_addr (rd_addr),
        .rd_strobe (rd_strobe), .wr_inhibit (wr_inhibit), .read_ack (read_ack),
        .byte_valid (byte_valid), .byte_data (byte_data)
    );

    function automatic logic [15:0] word_of(input logic [AW-1:0] a);
        return {8'(a) ^ 8'hA5, 8'(a) + 8'h3C};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Byte-port readiness: always, alternating, or pseudo-random.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (mode)
                0: byte_ready = 1'b1;
                1: byte_ready = ~byte_ready;
                default: byte_ready = lfsr[0];
            endcase
        end
    end

    // Monitor: memory model, address order, pacing, byte order and hold, end of frame.
    always @(negedge clk) begin
        cyc++;
        rd_data = pend ? word_of(pend_addr) : 16'hDEAD;
        if (running) begin
            if (hold_pend)
                chk(byte_valid && byte_data == hold_data, "R8", int'(byte_data), int'(hold_data));
            if (byte_valid && byte_ready) begin
                chk(byte_data == exp_q[head], "R7", int'(byte_data), int'(exp_q[head]));
                head++;
                last_acc = cyc;
            end
            if (rd_strobe) begin
                chk(rd_addr == exp_addr, "R5", int'(rd_addr), int'(exp_addr));
                chk(!byte_valid, "R7", int'(byte_valid), 0);
                if (nstrb > 0) begin
                    if (mode == 0) chk(cyc - last_strb == GAP_FAST, "R6", cyc - last_strb, GAP_FAST);
                    else           chk(cyc - last_strb >= PACE, "R6", cyc - last_strb, PACE);
                end
                exp_q[tail]     = word_of(exp_addr)[15:8];
                exp_q[tail + 1] = word_of(exp_addr)[7:0];
                tail += 2;
                exp_addr = exp_addr + 1'b1;
                nstrb++;
                last_strb = cyc;
            end
            if (ack_prev && !read_ack) begin
                chk(!wr_inhibit, "R9", int'(wr_inhibit), 0);
                chk(cyc == last_acc + 1, "R9", cyc - last_acc, 1);
                done_flag = 1'b1;
            end
        end
        hold_pend = byte_valid && !byte_ready;
        hold_data = byte_data;
        pend = rd_strobe;
        pend_addr = rd_addr;
        ack_prev = read_ack;
    end

    task automatic pulse_done_only();
        @(posedge clk); #1 frame_done = 1'b1;
        @(posedge clk); #1 frame_done = 1'b0;
    endtask

    task automatic run_frame(input int m, input logic inject);
        mode = m;
        exp_addr = ST; head = 0; tail = 0; nstrb = 0;
        last_strb = 0; last_acc = 0; done_flag = 1'b0;
        pulse_done_only();
        repeat (4) @(negedge clk);
        chk(!wr_inhibit && !read_ack && !rd_strobe, "R2", int'(read_ack), 0);
        @(posedge clk); #1 read_req = 1'b1;
        @(posedge clk); #1 read_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(!wr_inhibit && !read_ack, "R3", int'(wr_inhibit), 0);
        running = 1'b1;
        pulse_done_only();
        @(negedge clk);
        chk(wr_inhibit && !read_ack, "R3", int'(read_ack), 0);
        @(negedge clk);
        chk(read_ack && !rd_strobe, "R3", int'(read_ack), 1);
        @(negedge clk);
        chk(rd_strobe == 1'b1, "R4", int'(rd_strobe), 1);
        if (inject) begin
            repeat (20) @(posedge clk);
            #1 read_req = 1'b1; frame_done = 1'b1;
            @(posedge clk); #1 read_req = 1'b0; frame_done = 1'b0;
        end
        for (int i = 0; i < 3000 && !done_flag; i++) @(negedge clk);
        chk(done_flag, "R9", int'(done_flag), 1);
        chk(nstrb == NPIX, "R5", nstrb, NPIX);
        chk(head == 2 * NPIX && tail == 2 * NPIX, inject ? "R10" : "R7", head, 2 * NPIX);
        repeat (10) @(negedge clk);
        chk(!read_ack && !rd_strobe && !byte_valid, inject ? "R10" : "R9", int'(read_ack), 0);
        running = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (60000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        pend = 1'b0; hold_pend = 1'b0; ack_prev = 1'b0; pend_addr = '0; hold_data = '0;
        repeat (3) @(negedge clk);
        chk(!read_ack && !wr_inhibit && !rd_strobe && !byte_valid, "R1", int'(read_ack), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!read_ack && !wr_inhibit && !rd_strobe && !byte_valid, "R1", int'(wr_inhibit), 0);
        run_frame(0, 1'b0);
        run_frame(1, 1'b0);
        run_frame(2, 1'b0);
        run_frame(0, 1'b1);
        run_frame(2, 1'b1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule